// File: doc/BRIEF.md
# Register Operate Unit with Sign Flags

This block is the execute stage of a small 16-bit load/store processor. It supports three operations: add, bitwise AND and bitwise NOT. It holds eight 16-bit general registers. A start strobe presents one instruction word. On the next clock edge the unit reads its operands, computes the result, writes the result to the destination register, and updates a set of three condition flags: negative, zero and positive. None of the operations touches memory.

Add and AND take their second operand from one of two places. When bit 5 of the instruction is 0, it comes from a second register. When bit 5 is 1, it is a 5-bit literal, sign-extended to the data width. NOT uses only the first source. Unknown opcodes and malformed NOT words are reported as illegal and change nothing. A debug write port loads registers for testing.

Top module: `opunit`

## Requirements
- R1: After reset, all registers read 0. The flags are zero=1, negative=0, positive=0. The result is 0, and wb_valid, done and illegal are 0.
- R2: Instruction fields are opcode [15:12], destination [11:9], first source [8:6] and mode [5]. The second source register is [2:0]. Opcode 4'b0001 adds. When start is sampled high at a clock edge, the result, wb_valid and done appear one cycle after that edge, for that cycle only. The destination register holds the new value from then on.
- R3: For add and AND, mode bit 1 uses the literal [4:0], sign-extended to 16 bits, as the second operand. Mode bit 0 uses the register selected by [2:0].
- R4: Opcode 4'b0101 writes the bitwise AND of its two operands.
- R5: Opcode 4'b1001 with [5:0] = 6'b111111 writes the bitwise inverse of the first source.
- R6: On every write-back, exactly one flag is set. Negative is set when bit 15 of the result is 1. Zero is set when the result is 0. Otherwise positive is set.
- R7: The flags change only on a write-back. An illegal instruction leaves them unchanged.
- R8: Any opcode other than 4'b0001, 4'b0101 or 4'b1001 pulses illegal together with done. It does not assert wb_valid and leaves every register unchanged.
- R9: A NOT word whose [5:0] is not all ones is illegal and is handled as in R8.
- R10: A source register may also be the destination. The result is computed from the value the register held before the write.
- R11: When dbg_we is high at a clock edge, dbg_data is written into register dbg_addr. A write-back to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Execute the instruction presented on instr |
| instr | input | 16 | Instruction word |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 3 | Debug write register index |
| dbg_data | input | 16 | Debug write data |
| result | output | 16 | Last computed result |
| wb_valid | output | 1 | Write-back performed this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |
| done | output | 1 | Instruction completed this cycle |
| illegal | output | 1 | Instruction was rejected this cycle |

## Verification
Register contents can only be seen through later instructions. Showing that an illegal word changed no register, and did not move the flags, therefore needs a follow-up add of literal zero to the same register, checked against the model. Two cases need chained sequences: an in-place sequence in which the destination is also a source, and a subtraction built from NOT, add-one and add. The chains end in positive, zero and negative results, so every flag state is reached. A long run of mixed random words, including malformed NOT words and unknown opcodes, is then compared against the behavioural model.

// File: rtl/opunit.sv
module opunit #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_data,
  output logic [DW-1:0] result,
  output logic          wb_valid,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_p,
  output logic          done,
  output logic          illegal
);
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;

  logic [DW-1:0] rf [NREG];

  wire [3:0]    opc  = instr[15:12];
  wire [AW-1:0] dst  = instr[9+AW-1:9];
  wire [AW-1:0] src1 = instr[6+AW-1:6];
  wire [AW-1:0] src2 = instr[AW-1:0];
  wire          imm  = instr[5];

  wire [DW-1:0] opa = rf[src1];
  wire [DW-1:0] opb = imm ? {{(DW-5){instr[4]}}, instr[4:0]} : rf[src2];

  logic [DW-1:0] alu;
  logic          legal;

  always_comb begin
    alu   = '0;
    legal = 1'b0;
    case (opc)
      OP_ADD: begin alu = opa + opb; legal = 1'b1; end
      OP_AND: begin alu = opa & opb; legal = 1'b1; end
      OP_NOT: begin alu = ~opa; legal = (instr[5:0] == 6'b111111); end
      default: ;
    endcase
  end

  wire do_wb = start && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (dbg_we) rf[dbg_addr] <= dbg_data;
      if (do_wb)  rf[dst] <= alu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      wb_valid <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b1;
      flag_p   <= 1'b0;
    end else begin
      wb_valid <= do_wb;
      done     <= start;
      illegal  <= start && !legal;
      if (do_wb) begin
        result <= alu;
        flag_n <= alu[DW-1];
        flag_z <= (alu == '0);
        flag_p <= !alu[DW-1] && (alu != '0);
      end
    end
  end

  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  p_flags_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (flag_z == (result == '0)) && (flag_n == result[DW-1]));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> $stable({flag_n, flag_z, flag_p}));

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_illegal_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !wb_valid);

  p_wb_has_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
endmodule

// File: tb/sim_opunit.sv
`timescale 1ns/1ps
module sim_opunit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] instr = '0;
  logic        dbg_we = 0;
  logic [2:0]  dbg_addr = '0;
  logic [15:0] dbg_data = '0;
  logic [15:0] result;
  logic        wb_valid, flag_n, flag_z, flag_p, done, illegal;

  opunit u0 (.clk, .rst_n, .start, .instr, .dbg_we, .dbg_addr, .dbg_data,
             .result, .wb_valid, .flag_n, .flag_z, .flag_p, .done, .illegal);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_rf [8];
  logic [2:0]  m_fl = 3'b010;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] e_add_r(int d, int s1, int s2);
    return {4'b0001, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] e_add_i(int d, int s1, int im);
    return {4'b0001, 3'(d), 3'(s1), 1'b1, 5'(im)};
  endfunction
  function automatic logic [15:0] e_and_r(int d, int s1, int s2);
    return {4'b0101, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] e_and_i(int d, int s1, int im);
    return {4'b0101, 3'(d), 3'(s1), 1'b1, 5'(im)};
  endfunction
  function automatic logic [15:0] e_not(int d, int s1);
    return {4'b1001, 3'(d), 3'(s1), 6'b111111};
  endfunction

  task automatic dbg_load(input int a, input logic [15:0] v, input string tag);
    @(negedge clk);
    dbg_we = 1; dbg_addr = 3'(a); dbg_data = v;
    @(negedge clk);
    dbg_we = 0;
    m_rf[a] = v;
  endtask

  task automatic run(input logic [15:0] ins, input string tag);
    logic [15:0] a, b, r;
    bit leg;
    a = m_rf[ins[8:6]];
    b = ins[5] ? {{11{ins[4]}}, ins[4:0]} : m_rf[ins[2:0]];
    leg = 1; r = '0;
    case (ins[15:12])
      4'b0001: r = a + b;
      4'b0101: r = a & b;
      4'b1001: begin r = ~a; leg = (ins[5:0] == 6'h3f); end
      default: leg = 0;
    endcase
    @(negedge clk);
    instr = ins; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1, {tag, " done"}, done, 1);
    chk(illegal == !leg, {tag, " illegal"}, illegal, !leg);
    chk(wb_valid == leg, {tag, " wb_valid"}, wb_valid, leg);
    if (leg) begin
      chk(result == r, {tag, " result"}, result, r);
      m_rf[ins[11:9]] = r;
      m_fl = r[15] ? 3'b100 : (r == 0) ? 3'b010 : 3'b001;
    end
    chk({flag_n, flag_z, flag_p} == m_fl, {tag, " flags"}, {flag_n, flag_z, flag_p}, m_fl);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    #20 rst_n = 1;
    @(negedge clk);
    chk({flag_n, flag_z, flag_p} == 3'b010, "R1 flags", {flag_n, flag_z, flag_p}, 3'b010);
    chk(result == 0 && !wb_valid && !done && !illegal, "R1 outputs", {result, wb_valid, done, illegal}, 0);
    for (int i = 0; i < 8; i++) run(e_add_i(i, i, 0), "R1 reg zero");

    dbg_load(1, 16'd9, "R11");
    dbg_load(2, 16'd5, "R11");
    run(e_add_i(1, 1, 0), "R11 readback");
    run(e_add_r(3, 1, 2), "R2 add reg");
    @(negedge clk);
    chk(!done && !wb_valid, "R2 single pulse", {done, wb_valid}, 0);
    run(e_add_i(4, 1, -3), "R3 add neg imm");
    run(e_add_i(4, 1, 15), "R3 add pos imm");
    run(e_and_r(5, 1, 2), "R4 and reg");
    run(e_and_i(5, 1, 12), "R4 and imm");
    run(e_and_i(5, 5, 0), "R4 clear");
    run(e_not(6, 2), "R5 not");

    run(e_not(3, 2), "R10 sub step not");
    run(e_add_i(3, 3, 1), "R10 sub step inc");
    run(e_add_r(3, 1, 3), "R6 sub positive");
    run(e_add_r(7, 2, 2), "R10 double");
    run(e_not(0, 1), "R6 negative");
    run(e_and_i(0, 0, 0), "R6 zero");
    run(e_not(0, 0), "R10 not self");

    run({4'b0011, 3'd1, 3'd2, 6'd0}, "R8 bad opcode");
    run({4'b1111, 3'd0, 3'd0, 6'd0}, "R8 bad opcode2");
    run({4'b1001, 3'd2, 3'd1, 6'b111110}, "R9 bad not");
    run(e_add_i(1, 1, 0), "R8 dest unchanged");
    run(e_add_i(2, 2, 0), "R9 dest unchanged");

    @(negedge clk);
    dbg_we = 1; dbg_addr = 3'd4; dbg_data = 16'h1234;
    instr = e_add_i(4, 2, 1); start = 1;
    @(negedge clk);
    dbg_we = 0; start = 0;
    m_rf[4] = m_rf[2] + 16'd1;
    m_fl = m_rf[4][15] ? 3'b100 : (m_rf[4] == 0) ? 3'b010 : 3'b001;
    run(e_add_i(4, 4, 0), "R11 wb priority");

    for (int k = 0; k < 400; k++) begin
      int sel, d, s1, s2, im;
      sel = $urandom % 12; d = $urandom % 8; s1 = $urandom % 8;
      s2 = $urandom % 8; im = $urandom % 32;
      if (k % 40 == 0) dbg_load(d, 16'($urandom), "R11 random");
      case (sel)
        0, 1: run(e_add_r(d, s1, s2), "R2 random");
        2, 3: run(e_add_i(d, s1, im), "R3 random");
        4:    run(e_and_r(d, s1, s2), "R4 random");
        5:    run(e_and_i(d, s1, im), "R4 random imm");
        6, 7: run(e_not(d, s1), "R5 random");
        8:    run({4'b1001, 3'(d), 3'(s1), 6'(im)}, "R9 random");
        9:    run({4'(4'b0010 + 4'(im % 3) * 4'd4), 3'(d), 3'(s1), 6'(im)}, "R8 random");
        default: run(e_add_r(d, d, d), "R10 random");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule